// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Snooping

This block holds the instructions that wait for one arithmetic functional unit in an out-of-order core. The issue stage writes an instruction into a free slot of the pool. Each source operand comes in either as a finished value or as the tag of the slot that will produce it. Every slot has a tag, and the issue side learns which tag its instruction received, so that later consumers can name it as their producer.

Pending operands are filled by watching a shared result bus. When a tag and a data word appear on that bus, every waiting operand that names that tag copies the data. A result that is broadcast in the same cycle as an issue is forwarded into the new slot at once. The pool offers the lowest-numbered slot whose two operands are both present to the functional unit. A slot that has been handed over is not offered again. The slot is released when its own tag appears on the bus.

Top module: `rs_pool`

## Requirements
- R1: After reset no slot is occupied: `iss_ready` is 1, `iss_tag` is 1, `disp_valid` is 0 and `disp_tag` is 0.
- R2: `iss_tag` is one plus the index of the lowest free slot. `iss_ready` is 0 when every slot is occupied, and an issue attempted while `iss_ready` is 0 changes no slot.
- R3: Slot tags run from 1 to NUM_ENTRIES. A source tag of 0 means the accompanying value is already final, and the pool stores that value unchanged.
- R4: A slot is offered for dispatch only when both of its operand tags are 0. It appears on the dispatch port in the cycle after its last operand arrives.
- R5: A bus beat with a nonzero tag is captured by every held operand that waits on that tag, in all slots at once. A value supplied at issue together with a nonzero tag is discarded.
- R6: When a bus beat arrives in the same cycle as an issue whose source tag matches it, the bus data is written into the new slot, and that operand starts out ready.
- R7: At most one slot is offered per cycle, namely the lowest-indexed ready one. A slot taken with `disp_ready` high is not offered again. While `disp_ready` is low, nothing is taken.
- R8: A slot becomes free in the cycle after its own tag is broadcast, and `iss_tag` reflects this immediately.
- R9: The opcode given at issue leaves unchanged on `disp_op`, together with the slot's operand values and `disp_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode to be stored |
| iss_val_a | input | DATA_W | First operand value |
| iss_tag_a | input | TAG_W | First operand producer tag, 0 means the value is final |
| iss_val_b | input | DATA_W | Second operand value |
| iss_tag_b | input | TAG_W | Second operand producer tag, 0 means the value is final |
| iss_ready | output | 1 | A free slot exists |
| iss_tag | output | TAG_W | Tag the next issue will receive (0 when full) |
| bus_valid | input | 1 | Result bus beat present |
| bus_tag | input | TAG_W | Tag of the broadcast result |
| bus_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A ready slot is offered |
| disp_ready | input | 1 | Functional unit takes the offered slot |
| disp_op | output | OP_W | Opcode of the offered slot |
| disp_a | output | DATA_W | First operand of the offered slot |
| disp_b | output | DATA_W | Second operand of the offered slot |
| disp_tag | output | TAG_W | Tag of the offered slot (0 when none) |

## Verification
The hardest situation to reach is a broadcast that lands in the same cycle as the issue of its consumer. It has to coincide with a free slot and with a producer that has already been dispatched but not yet retired. The stimulus builds this on purpose. It issues a producer, takes it, and then issues the consumer while the bus carries the producer's tag. It does this for every combination of pending operands, both with the same-cycle broadcast and with a later one. A scripted sequence also fills the pool with interdependent slots. It then retires producers one by one, so that priority, multi-slot capture and full-pool stalling are all observed.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;

  // Life of one slot: empty, holding an instruction, handed to the unit.
  typedef enum logic [1:0] {
    SLOT_FREE     = 2'd0,
    SLOT_HELD     = 2'd1,
    SLOT_LAUNCHED = 2'd2
  } slot_state_e;

endpackage

// File: rtl/rs_operand.sv
module rs_operand #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_val,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic [DATA_W-1:0] val,
  output logic [TAG_W-1:0]  tag,
  output logic              avail
);

  logic [DATA_W-1:0] val_q, val_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic              upd_en;
  logic              fwd_hit, snoop_hit;

  always_comb begin
    fwd_hit   = bus_valid && (ld_tag != '0) && (ld_tag == bus_tag);
    snoop_hit = bus_valid && (tag_q != '0) && (tag_q == bus_tag);
    upd_en    = 1'b0;
    val_d     = val_q;
    tag_d     = tag_q;
    if (load) begin
      upd_en = 1'b1;
      val_d  = fwd_hit ? bus_data : ld_val;
      tag_d  = fwd_hit ? '0 : ld_tag;
    end else if (snoop_hit) begin
      upd_en = 1'b1;
      val_d  = bus_data;
      tag_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      tag_q <= '0;
    end else if (upd_en) begin
      val_q <= val_d;
      tag_q <= tag_d;
    end
  end

  assign val   = val_q;
  assign tag   = tag_q;
  assign avail = (tag_q == '0);

endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pool_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 3,
  parameter int MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              launch,
  input  logic [OP_W-1:0]   op_in,
  input  logic [DATA_W-1:0] val_a_in,
  input  logic [TAG_W-1:0]  tag_a_in,
  input  logic [DATA_W-1:0] val_b_in,
  input  logic [TAG_W-1:0]  tag_b_in,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op_out,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] b_out
);

  localparam logic [TAG_W-1:0] SELF_TAG = TAG_W'(MY_TAG);

  slot_state_e       state_q, state_d;
  logic [OP_W-1:0]   op_q;
  logic              a_avail, b_avail;
  logic              own_bcast;
  logic [TAG_W-1:0]  a_tag_unused, b_tag_unused;

  assign own_bcast = bus_valid && (bus_tag == SELF_TAG);

  always_comb begin
    state_d = state_q;
    if (alloc) begin
      state_d = SLOT_HELD;
    end else if (own_bcast && (state_q != SLOT_FREE)) begin
      state_d = SLOT_FREE;
    end else if (launch) begin
      state_d = SLOT_LAUNCHED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_FREE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
    end else if (alloc) begin
      op_q <= op_in;
    end
  end

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opnd_a (
    .clk(clk), .rst_n(rst_n), .load(alloc),
    .ld_val(val_a_in), .ld_tag(tag_a_in),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .val(a_out), .tag(a_tag_unused), .avail(a_avail)
  );

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opnd_b (
    .clk(clk), .rst_n(rst_n), .load(alloc),
    .ld_val(val_b_in), .ld_tag(tag_b_in),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .val(b_out), .tag(b_tag_unused), .avail(b_avail)
  );

  assign busy   = (state_q != SLOT_FREE);
  assign ready  = (state_q == SLOT_HELD) && a_avail && b_avail;
  assign op_out = op_q;

endmodule

// File: rtl/rs_lowest_pick.sv
module rs_lowest_pick #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    gnt   = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        gnt   = '0;
        gnt[i] = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int NUM_ENTRIES = 4,
  parameter int DATA_W      = 16,
  parameter int OP_W        = 4,
  parameter int TAG_W       = $clog2(NUM_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] iss_val_a,
  input  logic [TAG_W-1:0]  iss_tag_a,
  input  logic [DATA_W-1:0] iss_val_b,
  input  logic [TAG_W-1:0]  iss_tag_b,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [TAG_W-1:0]  disp_tag
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0] busy_vec, ready_vec;
  logic [NUM_ENTRIES-1:0] alloc_gnt, disp_gnt;
  logic [NUM_ENTRIES-1:0] alloc_vec, launch_vec;
  logic [IDX_W-1:0]       alloc_idx, disp_idx;
  logic                   free_found, ready_found;
  logic                   iss_fire, disp_fire;

  logic [OP_W-1:0]   op_arr [NUM_ENTRIES];
  logic [DATA_W-1:0] a_arr  [NUM_ENTRIES];
  logic [DATA_W-1:0] b_arr  [NUM_ENTRIES];

  rs_lowest_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_alloc_pick (
    .req(~busy_vec), .found(free_found), .gnt(alloc_gnt), .idx(alloc_idx)
  );

  rs_lowest_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_disp_pick (
    .req(ready_vec), .found(ready_found), .gnt(disp_gnt), .idx(disp_idx)
  );

  assign iss_fire   = iss_valid && free_found;
  assign disp_fire  = ready_found && disp_ready;
  assign alloc_vec  = alloc_gnt & {NUM_ENTRIES{iss_fire}};
  assign launch_vec = disp_gnt & {NUM_ENTRIES{disp_fire}};

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    rs_slot #(
      .DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W), .MY_TAG(g + 1)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_vec[g]), .launch(launch_vec[g]),
      .op_in(iss_op),
      .val_a_in(iss_val_a), .tag_a_in(iss_tag_a),
      .val_b_in(iss_val_b), .tag_b_in(iss_tag_b),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
      .busy(busy_vec[g]), .ready(ready_vec[g]),
      .op_out(op_arr[g]), .a_out(a_arr[g]), .b_out(b_arr[g])
    );
  end

  assign iss_ready  = free_found;
  assign iss_tag    = free_found ? (TAG_W'(alloc_idx) + TAG_W'(1)) : '0;
  assign disp_valid = ready_found;
  assign disp_tag   = ready_found ? (TAG_W'(disp_idx) + TAG_W'(1)) : '0;
  assign disp_op    = op_arr[disp_idx];
  assign disp_a     = a_arr[disp_idx];
  assign disp_b     = b_arr[disp_idx];

endmodule

// File: rtl/rs_pool_checker.sv
module rs_pool_checker #(
  parameter int NUM_ENTRIES = 4,
  parameter int TAG_W       = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   iss_valid,
  input logic                   iss_ready,
  input logic [TAG_W-1:0]       iss_tag,
  input logic                   bus_valid,
  input logic [TAG_W-1:0]       bus_tag,
  input logic                   disp_valid,
  input logic                   disp_ready,
  input logic [TAG_W-1:0]       disp_tag,
  input logic [NUM_ENTRIES-1:0] busy_vec,
  input logic [NUM_ENTRIES-1:0] launch_vec
);

  logic [NUM_ENTRIES-1:0] iss_hot, bus_hot;

  always_comb begin
    iss_hot = '0;
    bus_hot = '0;
    if (iss_valid && iss_ready && iss_tag != '0 && int'(iss_tag) <= NUM_ENTRIES)
      iss_hot = NUM_ENTRIES'(1) << (iss_tag - TAG_W'(1));
    if (bus_valid && bus_tag != '0 && int'(bus_tag) <= NUM_ENTRIES)
      bus_hot = NUM_ENTRIES'(1) << (bus_tag - TAG_W'(1));
  end

  // R3: offered tags stay within 1..NUM_ENTRIES
  a_r3_disp_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_tag != '0 && int'(disp_tag) <= NUM_ENTRIES));

  // R2: a full pool refuses issue
  a_r2_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy_vec) |-> !iss_ready);

  // R2: accepted issue occupies the advertised slot
  a_r2_issue_occupies: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_hot != '0) |=> ((busy_vec & $past(iss_hot)) == $past(iss_hot)));

  // R8: own-tag broadcast frees the slot
  a_r8_free_on_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hot != '0) |=> ((busy_vec & $past(bus_hot) & ~$past(iss_hot)) == '0));

  // R7: at most one slot handed over per cycle
  a_r7_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch_vec));

  // R7: a handed-over slot is not offered in the next cycle
  a_r7_no_reoffer: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> !(disp_valid && disp_tag == $past(disp_tag)));

endmodule

bind rs_pool rs_pool_checker #(
  .NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W)
) u_rs_pool_checker (
  .clk(clk), .rst_n(rst_n),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag),
  .bus_valid(bus_valid), .bus_tag(bus_tag),
  .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_tag(disp_tag),
  .busy_vec(busy_vec), .launch_vec(launch_vec)
);

// File: tb/rs_pool_test.sv
module rs_pool_test;

  localparam int N      = 4;
  localparam int DATA_W = 16;
  localparam int OP_W   = 4;
  localparam int TAG_W  = $clog2(N + 1);

  logic              clk;
  logic              rst_n;
  logic              iss_valid;
  logic [OP_W-1:0]   iss_op;
  logic [DATA_W-1:0] iss_val_a, iss_val_b;
  logic [TAG_W-1:0]  iss_tag_a, iss_tag_b;
  logic              iss_ready;
  logic [TAG_W-1:0]  iss_tag;
  logic              bus_valid;
  logic [TAG_W-1:0]  bus_tag;
  logic [DATA_W-1:0] bus_data;
  logic              disp_valid, disp_ready;
  logic [OP_W-1:0]   disp_op;
  logic [DATA_W-1:0] disp_a, disp_b;
  logic [TAG_W-1:0]  disp_tag;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  rs_pool #(.NUM_ENTRIES(N), .DATA_W(DATA_W), .OP_W(OP_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_val_a(iss_val_a), .iss_tag_a(iss_tag_a),
    .iss_val_b(iss_val_b), .iss_tag_b(iss_tag_b),
    .iss_ready(iss_ready), .iss_tag(iss_tag),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_op(disp_op), .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    iss_valid  = 1'b0;
    bus_valid  = 1'b0;
    disp_ready = 1'b0;
  endtask

  task automatic issue(input int op, input int va, input int ta, input int vb, input int tb);
    iss_valid = 1'b1;
    iss_op    = OP_W'(op);
    iss_val_a = DATA_W'(va);
    iss_tag_a = TAG_W'(ta);
    iss_val_b = DATA_W'(vb);
    iss_tag_b = TAG_W'(tb);
  endtask

  task automatic bcast(input int t, input int d);
    bus_valid = 1'b1;
    bus_tag   = TAG_W'(t);
    bus_data  = DATA_W'(d);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle();
    repeat (2) cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic expect_disp(input string req, input int t, input int op, input int a, input int b);
    chk({req, " disp_valid"}, int'(disp_valid), 1);
    chk({req, " disp_tag"},   int'(disp_tag), t);
    chk({req, " disp_op"},    int'(disp_op), op);
    chk({req, " disp_a"},     int'(disp_a), a);
    chk({req, " disp_b"},     int'(disp_b), b);
  endtask

  initial begin
    iss_op = '0; iss_val_a = '0; iss_val_b = '0; iss_tag_a = '0; iss_tag_b = '0;
    bus_tag = '0; bus_data = '0;
    do_reset();

    // R1 reset state
    chk("R1 iss_ready", int'(iss_ready), 1);
    chk("R1 iss_tag", int'(iss_tag), 1);
    chk("R1 disp_valid", int'(disp_valid), 0);
    chk("R1 disp_tag", int'(disp_tag), 0);

    // R3 R9: ready operands, offered next cycle
    issue(5, 10, 0, 20, 0); cyc(); idle();
    expect_disp("R3 R9", 1, 5, 10, 20);
    chk("R2 iss_tag after one issue", int'(iss_tag), 2);

    // fill with dependents of slot 1 and 2
    issue(6, 777, 1, 7, 0);  cyc();
    issue(7, 0, 1, 0, 1);    cyc();
    issue(8, 30, 0, 999, 2); cyc(); idle();
    chk("R2 full iss_ready", int'(iss_ready), 0);
    chk("R2 full iss_tag", int'(iss_tag), 0);
    chk("R7 lowest with waiting others", int'(disp_tag), 1);

    // R2 issue while full is ignored
    issue(15, 1234, 0, 1, 0); cyc(); idle();
    chk("R2 ignored issue ready", int'(iss_ready), 0);
    expect_disp("R2 ignored issue", 1, 5, 10, 20);

    // R7 disp_ready low holds, then take slot 1
    cyc();
    chk("R7 no take without ready", int'(disp_tag), 1);
    disp_ready = 1'b1; cyc(); idle();
    chk("R7 not reoffered", int'(disp_valid), 0);

    // R5 R8 broadcast slot 1 result
    bcast(1, 100); cyc(); idle();
    chk("R8 freed ready", int'(iss_ready), 1);
    chk("R8 freed tag", int'(iss_tag), 1);
    expect_disp("R5 capture", 2, 6, 100, 7);

    disp_ready = 1'b1; cyc(); idle();
    expect_disp("R5 R7 both captured", 3, 7, 100, 100);

    // R6 same-cycle forwarding into new slot 1, R5 into slot 4
    issue(9, 0, 2, 9, 0); bcast(2, 55); cyc(); idle();
    expect_disp("R6 R7 forward", 1, 9, 55, 9);
    chk("R8 slot2 freed", int'(iss_tag), 2);

    disp_ready = 1'b1; cyc(); idle();
    expect_disp("R7 next", 3, 7, 100, 100);
    disp_ready = 1'b1; cyc(); idle();
    expect_disp("R5 late capture", 4, 8, 30, 55);

    // sweep: pending-operand mask x broadcast timing
    for (int m = 0; m < 4; m++) begin
      for (int fwd = 0; fwd < 2; fwd++) begin
        int bd, ea, eb, cop;
        bd  = 500 + m * 7 + fwd;
        cop = (m * 3 + fwd + 1) & 15;
        ea  = (m & 1) ? bd : 100 + m;
        eb  = (m & 2) ? bd : 200 + m;
        do_reset();
        issue(m, m * 3 + 1, 0, fwd + 2, 0); cyc(); idle();
        chk("R4 sweep producer", int'(disp_tag), 1);
        disp_ready = 1'b1; cyc(); idle();
        chk("R7 sweep taken", int'(disp_valid), 0);
        issue(cop, 100 + m, (m & 1) ? 1 : 0, 200 + m, (m & 2) ? 1 : 0);
        if (fwd == 1) bcast(1, bd);
        cyc(); idle();
        if (fwd == 0) begin
          chk("R4 sweep wait", int'(disp_valid), (m == 0) ? 1 : 0);
          chk("R2 sweep tag busy", int'(iss_tag), 3);
          bcast(1, bd); cyc(); idle();
        end
        expect_disp((fwd == 1) ? "R6 sweep" : "R5 sweep", 2, cop, ea, eb);
        chk("R8 sweep free", int'(iss_tag), 1);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule